// File: doc/BRIEF.md
# Input Freeze Latch Bank

This block sits between a row of input pins and the internal routing of a low-power programmable-logic fabric. It cuts switching activity there. Each pin reaches the routing through a transparent latch. A shared gating rail closes that latch, but only for pins that have been enrolled. While the rail is high, an enrolled pin presents the level it had when it was frozen, so toggling on that pin stops propagating inward. A pin that is not enrolled always passes straight through.

The rail has two possible sources. It can come from a dedicated external enable input, or from a signal produced by internal logic, such as a counter or state-machine output. The chosen rail is copied to a monitor output so it can be observed off-chip. A synchronous write port loads two things together on one clock edge: the per-pin enrolment mask and the rail-source select.

Top module: `input_freeze_bank`

## Requirements
- R1: After reset the enrolment mask is all zeros and the rail source is the external enable. Every output then follows its pin, and `railMon` follows `extEnable`.
- R2: While the rail is low, each enrolled pin's output equals its pin in the same cycle. No register lies in this path.
- R3: While the rail is high, an enrolled pin's output holds the level the pin had when the rail rose. Later pin changes do not affect it.
- R4: A pin whose mask bit is 0 follows its input at all times, whatever the rail does.
- R5: Bit i of `cfgMask` enrols pin i. Any subset of pins may be enrolled at once.
- R6: A write (`cfgWrEn` high at a rising clock edge) loads the mask and the select together. `cfgSelInternal`=0 picks `extEnable` and `cfgSelInternal`=1 picks `intRail`. The source that is not selected has no effect.
- R7: `railMon` always equals the selected rail source.
- R8: When the mask is written while the rail is high, pins that stay enrolled keep their held value. A pin that is newly enrolled freezes at its level on the write edge. A pin whose bit is cleared follows its input again right after that edge.
- R9: When the rail falls, every held output returns to following its pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration write |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Pin levels arriving from the pads |
| extEnable | input | 1 | Dedicated external rail enable |
| intRail | input | 1 | Rail driven by internal logic |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgMask | input | NUM_PINS | Enrolment mask to load (bit i = pin i) |
| cfgSelInternal | input | 1 | Rail source to load (1 = internal) |
| coreOut | output | NUM_PINS | Pin levels delivered to the routing |
| railMon | output | 1 | Copy of the selected rail |

## Verification
The gating rail being high and a configuration write can fall in the same cycle. Rewriting the mask while pins are frozen then releases some pins, keeps others held, and freezes new ones, all on a single edge. The bench provokes this by raising the rail and then changing the pin levels. It then writes a mask that clears one enrolled bit, keeps another, and adds a new one. It judges each output bit against held levels and live levels that it works out itself, before the rail drops. The exhaustive sweep covers every mask, both rail sources, and every before/after pin pattern. In the sweep, the source that is not selected is always driven opposite to the selected one.

// File: rtl/freeze_pkg.sv
package freeze_pkg;
  // strobes from control to the latch datapath
  typedef struct packed {
    logic rail;      // selected gating rail, high = freeze enrolled pins
    logic maskLoad;  // load new enrolment mask this edge
  } freezeCtl_t;
endpackage

// File: rtl/freeze_ctrl.sv
module freeze_ctrl
  import freeze_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       extEnable,
  input  logic       intRail,
  input  logic       cfgWrEn,
  input  logic       cfgSelInternal,
  output freezeCtl_t ctl
);
  logic selInternalQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selInternalQ <= 1'b0;
    else if (cfgWrEn) selInternalQ <= cfgSelInternal;
  end

  always_comb begin
    ctl.rail     = selInternalQ ? intRail : extEnable;
    ctl.maskLoad = cfgWrEn;
  end
endmodule

// File: rtl/freeze_latch_path.sv
module freeze_latch_path
  import freeze_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  freezeCtl_t          ctl,
  input  logic [NUM_PINS-1:0] cfgMask,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] coreOut
);
  logic [NUM_PINS-1:0] enrolQ;
  logic [NUM_PINS-1:0] freeze;
  logic [NUM_PINS-1:0] heldQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enrolQ <= '0;
    else if (ctl.maskLoad) enrolQ <= cfgMask;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
    assign freeze[i] = ctl.rail & enrolQ[i];
    // transparent while not frozen, holds last level while frozen
    always_latch begin
      if (!freeze[i]) heldQ[i] = pinIn[i];
    end
  end

  assign coreOut = heldQ;
endmodule

// File: rtl/input_freeze_bank.sv
module input_freeze_bank
  import freeze_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                extEnable,
  input  logic                intRail,
  input  logic                cfgWrEn,
  input  logic [NUM_PINS-1:0] cfgMask,
  input  logic                cfgSelInternal,
  output logic [NUM_PINS-1:0] coreOut,
  output logic                railMon
);
  freezeCtl_t ctl;

  freeze_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .extEnable      (extEnable),
    .intRail        (intRail),
    .cfgWrEn        (cfgWrEn),
    .cfgSelInternal (cfgSelInternal),
    .ctl            (ctl)
  );

  freeze_latch_path #(.NUM_PINS(NUM_PINS)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .cfgMask (cfgMask),
    .pinIn   (pinIn),
    .coreOut (coreOut)
  );

  assign railMon = ctl.rail;
endmodule

// File: rtl/freeze_checker.sv
module freeze_checker #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] pinIn,
  input logic                extEnable,
  input logic                intRail,
  input logic                cfgWrEn,
  input logic [NUM_PINS-1:0] cfgMask,
  input logic                cfgSelInternal,
  input logic [NUM_PINS-1:0] coreOut,
  input logic                railMon
);
  logic [NUM_PINS-1:0] shadowMask;
  logic                shadowSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowMask <= '0;
      shadowSel  <= 1'b0;
    end else if (cfgWrEn) begin
      shadowMask <= cfgMask;
      shadowSel  <= cfgSelInternal;
    end
  end

  AST_RAIL_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    railMon == (shadowSel ? intRail : extEnable)); // R7

  AST_PASS_WHEN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !railMon |-> (coreOut == pinIn)); // R2

  AST_UNENROLLED_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (coreOut & ~shadowMask) == (pinIn & ~shadowMask)); // R4

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (railMon && $past(railMon) && !$past(cfgWrEn))
      |-> ((coreOut & shadowMask) == ($past(coreOut) & shadowMask))); // R3
endmodule

bind input_freeze_bank freeze_checker #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/sim_input_freeze_bank.sv
`timescale 1ns/1ps
module sim_input_freeze_bank;
  localparam int N = 4;
  localparam int LIM = 1 << N;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] pinIn = '0;
  logic         extEnable = 1'b0;
  logic         intRail = 1'b0;
  logic         cfgWrEn = 1'b0;
  logic [N-1:0] cfgMask = '0;
  logic         cfgSelInternal = 1'b0;
  logic [N-1:0] coreOut;
  logic         railMon;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  input_freeze_bank #(.NUM_PINS(N)) u0 (.*);

  always #2.5 clk = ~clk;

  task automatic chkV(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chkB(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [N-1:0] m, input logic sel);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgMask = m; cfgSelInternal = sel;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  // drive the rail through the chosen source, unselected source opposite
  task automatic setRail(input logic sel, input logic v);
    if (sel) begin intRail = v; extEnable = ~v; end
    else begin extEnable = v; intRail = ~v; end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state, mask zero and external source
    extEnable = 1'b1; intRail = 1'b0; pinIn = 4'b1011; #1;
    chkV("R1 pass after reset", coreOut, 4'b1011);
    chkB("R1 monitor external", railMon, 1'b1);
    pinIn = 4'b0110; #1;
    chkV("R1 no freeze with empty mask", coreOut, 4'b0110);
    extEnable = 1'b0;
    @(posedge clk); #1;

    // exhaustive sweep: R2 R3 R4 R5 R6 R7 R9
    for (int m = 0; m < LIM; m++) begin
      for (int s = 0; s < 2; s++) begin
        setRail(s[0], 1'b0);
        cfgWrite(m[N-1:0], s[0]);
        for (int p = 0; p < LIM; p++) begin
          setRail(s[0], 1'b0);
          pinIn = p[N-1:0]; #1;
          chkV("R2 transparent low", coreOut, p[N-1:0]);
          chkB("R6 R7 monitor low", railMon, 1'b0);
          setRail(s[0], 1'b1); #1;
          chkB("R6 R7 monitor high", railMon, 1'b1);
          for (int q = 0; q < LIM; q++) begin
            pinIn = q[N-1:0]; #1;
            chkV("R3 R4 R5 hold enrolled",
                 coreOut, (p[N-1:0] & m[N-1:0]) | (q[N-1:0] & ~m[N-1:0]));
          end
          setRail(s[0], 1'b0); #1;
          chkV("R9 release on fall", coreOut, pinIn);
          @(posedge clk); #1;
        end
      end
    end

    // R8: rewrite mask while rail high
    setRail(1'b0, 1'b0);
    cfgWrite(4'b0011, 1'b0);
    pinIn = 4'b0101; #1;
    setRail(1'b0, 1'b1); #1;
    pinIn = 4'b1010; #1;
    chkV("R8 before rewrite", coreOut, 4'b1001);
    cfgWrite(4'b0110, 1'b0);
    chkV("R8 at rewrite", coreOut, 4'b1000);
    pinIn = 4'b0101; #1;
    chkV("R8 after rewrite", coreOut, 4'b0001);
    setRail(1'b0, 1'b0); #1;
    chkV("R8 R9 rail falls", coreOut, 4'b0101);
    @(posedge clk); #1;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule